// File: doc/BRIEF.md
# Converter Serial Port and Power-State Model

This block is a synthesizable stand-in for the digital side of an eight-input, 12-bit sampling converter. It is meant for exercising a host controller without the real device. The host drives a conversion-start line, a serial clock and a serial data input. The model answers with a serial data output and its drive enable. All three host inputs are taken as already synchronous to the model clock, and their edges are found by comparing each input with its value one cycle earlier. A parameterized counter takes the place of the internal conversion clock. A 12-bit port supplies the value that each conversion "produces".

While a frame is being read, the model shifts the previous result out most significant bit first. At the same time it captures a six-bit configuration word. That word takes effect at the next conversion start. It selects an input-multiplexer code, the output format (straight binary or two's complement) and the low-power mode. The low-power mode is entered when the start line is still high at the end of a conversion. The model tracks an active, nap, sleep and waking state. It shortens the long reference settling after sleep to a parameterized count. A sticky flag records host protocol violations.

Top module: `adc_port_model`

## Requirements
- R1: After reset, busy, acq_ready, proto_err and mux_sel are 0, pwr_state is active (0), and the held configuration is all zeros (two's complement format, nap, multiplexer code 0).
- R2: A rising edge on convst while idle raises busy for exactly CONV_CYCLES clock cycles. Rising edges while busy is high neither restart nor extend the conversion.
- R3: sdo_oe is 0 in the cycle after convst is sampled high and whenever busy is high. It is 1 when convst is low and no conversion is running.
- R4: When a conversion ends, the result word is loaded so that sdo presents bit 11. Each later falling edge of sck, while sdo_oe is 1, moves the next lower bit onto sdo, down to bit 0.
- R5: The result is sample_in unchanged when the format bit of the configuration used by that conversion is 1. When the bit is 0 the result is sample_in with its top bit inverted (offset binary to two's complement).
- R6: sdi is captured on the first six rising sck edges that follow a convst falling edge or a conversion end, and not during a conversion. The first bit is the top bit of the word. Bits [5:2] are the multiplexer code, bit [1] is the format bit (1 = straight binary) and bit [0] is the sleep bit. The word is used from the next conversion start onward.
- R7: acq_ready becomes 1 once the sixth configuration bit is captured and returns to 0 at the next conversion start.
- R8: mux_sel shows the multiplexer code of the configuration latched at the most recent conversion start.
- R9: If convst is high when a conversion ends, pwr_state goes to nap (1) when the sleep bit in use is 0, or to sleep (2) when it is 1. If convst is low at that moment, pwr_state stays active (0).
- R10: A convst falling edge moves nap to active. It moves sleep to waking (3), which lasts exactly WAKE_CYCLES cycles before returning to active.
- R11: proto_err is set by any sck edge while busy is high, or by a conversion start while pwr_state is waking. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous active-high reset |
| convst | input | 1 | Conversion start / output enable line from host |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial configuration data from host |
| sample_in | input | DATA_W | Offset-binary value taken as the conversion result |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Drive enable for sdo (0 = high impedance) |
| busy | output | 1 | Conversion in progress |
| acq_ready | output | 1 | Full configuration word captured, acquiring |
| mux_sel | output | 4 | Multiplexer code for the current conversion |
| pwr_state | output | 2 | 0 active, 1 nap, 2 sleep, 3 waking |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The bench checks that a conversion cannot be restarted by toggling convst in the middle of a conversion. It then requires busy to fall exactly CONV_CYCLES cycles after the first edge; a model that re-armed on the later edge would stay busy too long. The low-power decision is exercised with a configuration read in one frame and used one conversion later. A design that applied the sleep or format bit immediately would enter the wrong state or emit a wrongly formatted word. The waking window is sampled at both of its ends. The two error sources are each provoked separately, and each is confirmed to survive until reset.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2,
    PWR_WAKING = 2'd3
  } pwr_e;

  // Serial order matters: first captured bit lands in mux[3], last in slp.
  typedef struct packed {
    logic [3:0] mux;
    logic       uni;
    logic       slp;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES > 1 ? CONV_CYCLES : 2);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LAST;
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sdi,
  input  logic              busy,
  input  logic              shift_en,
  input  logic              load,
  input  logic              frame_clr,
  input  logic              conv_start,
  input  logic [DATA_W-1:0] load_word,
  output logic              sdo,
  output cfg_t              cfg_pending,
  output logic              acq_ready
);
  localparam int CCW = $clog2(CFG_W + 1);
  localparam logic [CCW-1:0] C_LAST = CCW'(CFG_W - 1);
  localparam logic [CCW-1:0] C_FULL = CCW'(CFG_W);

  logic [DATA_W-1:0] out_sr;
  logic [CFG_W-2:0]  cfg_sr;
  logic [CCW-1:0]    cfg_cnt;

  assign sdo = out_sr[DATA_W-1];

  // Result shifter: load at end of conversion, MSB first on sck falls.
  always_ff @(posedge clk) begin
    if (rst)           out_sr <= '0;
    else if (load)     out_sr <= load_word;
    else if (shift_en) out_sr <= {out_sr[DATA_W-2:0], 1'b0};
  end

  // Configuration capture on the first CFG_W sck rises of a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_cnt     <= '0;
      cfg_sr      <= '0;
      cfg_pending <= '0;
      acq_ready   <= 1'b0;
    end else begin
      if (frame_clr) begin
        cfg_cnt <= '0;
      end else if (sck_rise && !busy && cfg_cnt != C_FULL) begin
        cfg_sr  <= {cfg_sr[CFG_W-3:0], sdi};
        cfg_cnt <= cfg_cnt + 1'b1;
        if (cfg_cnt == C_LAST) begin
          cfg_pending <= cfg_t'({cfg_sr, sdi});
          acq_ready   <= 1'b1;
        end
      end
      if (conv_start) acq_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_power_ctrl.sv
module adc_power_ctrl
  import adc_port_pkg::*;
#(
  parameter int WAKE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic convst,
  input  logic convst_fall,
  input  logic slp,
  input  logic conv_start,
  input  logic sck_edge,
  input  logic busy,
  output pwr_e state,
  output logic proto_err
);
  localparam int WW = $clog2(WAKE_CYCLES > 1 ? WAKE_CYCLES : 2);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYCLES - 1);

  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PWR_ACTIVE;
      wcnt      <= '0;
      proto_err <= 1'b0;
    end else begin
      if ((sck_edge && busy) || (conv_start && state == PWR_WAKING))
        proto_err <= 1'b1;
      case (state)
        PWR_ACTIVE: if (done && convst) state <= slp ? PWR_SLEEP : PWR_NAP;
        PWR_NAP:    if (convst_fall) state <= PWR_ACTIVE;
        PWR_SLEEP: begin
          if (convst_fall) begin
            state <= PWR_WAKING;
            wcnt  <= WAKE_LAST;
          end
        end
        default: begin
          if (wcnt == '0) state <= PWR_ACTIVE;
          else            wcnt  <= wcnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_port_model.sv
module adc_port_model
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 20,
  parameter int WAKE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convst,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              acq_ready,
  output logic [3:0]        mux_sel,
  output logic [1:0]        pwr_state,
  output logic              proto_err
);
  logic convst_q, sck_q;
  logic conv_rise, convst_fall, sck_rise, sck_fall, conv_start, done;
  cfg_t cfg_pending, cfg_cur;
  pwr_e pwr_st;
  logic [DATA_W-1:0] fmt_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      convst_q <= 1'b0;
      sck_q    <= 1'b0;
      cfg_cur  <= '0;
    end else begin
      convst_q <= convst;
      sck_q    <= sck;
      if (conv_start) cfg_cur <= cfg_pending;
    end
  end

  assign conv_rise   = convst & ~convst_q;
  assign convst_fall = ~convst & convst_q;
  assign sck_rise    = sck & ~sck_q;
  assign sck_fall    = ~sck & sck_q;
  assign conv_start  = conv_rise & ~busy;

  assign sdo_oe    = ~convst_q & ~busy;
  assign mux_sel   = cfg_cur.mux;
  assign pwr_state = pwr_st;
  assign fmt_word  = cfg_cur.uni ? sample_in
                                 : {~sample_in[DATA_W-1], sample_in[DATA_W-2:0]};

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (conv_start),
    .busy  (busy),
    .done  (done)
  );

  adc_serial_port #(.DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .sck_rise    (sck_rise),
    .sdi         (sdi),
    .busy        (busy),
    .shift_en    (sck_fall & sdo_oe),
    .load        (done),
    .frame_clr   (convst_fall | done),
    .conv_start  (conv_start),
    .load_word   (fmt_word),
    .sdo         (sdo),
    .cfg_pending (cfg_pending),
    .acq_ready   (acq_ready)
  );

  adc_power_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .convst      (convst),
    .convst_fall (convst_fall),
    .slp         (cfg_cur.slp),
    .conv_start  (conv_start),
    .sck_edge    (sck_rise | sck_fall),
    .busy        (busy),
    .state       (pwr_st),
    .proto_err   (proto_err)
  );
endmodule

// File: rtl/adc_port_checker.sv
module adc_port_checker #(
  parameter int CONV_CYCLES = 20
) (
  input logic       clk,
  input logic       rst,
  input logic       convst,
  input logic       sck,
  input logic       busy,
  input logic       sdo_oe,
  input logic       proto_err,
  input logic [1:0] pwr_state
);
  localparam int BW = $clog2(CONV_CYCLES + 1);
  localparam logic [BW-1:0] B_MAX  = BW'(CONV_CYCLES);
  localparam logic [BW-1:0] B_LAST = BW'(CONV_CYCLES - 1);

  logic [BW-1:0] bcnt;
  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R2: conversion never outlasts its window and always ends at its full length
  p_busy_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> bcnt < B_MAX);
  p_busy_length_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(bcnt) == B_LAST);

  // R3: output released while start line high or converting
  p_hiz_convst_r3: assert property (@(posedge clk) disable iff (rst)
    $past(convst) |-> !sdo_oe);
  p_hiz_busy_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sdo_oe);

  // R10: nap only leaves to active; sleep only leaves to waking
  p_nap_exit_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'd1 |=> (pwr_state == 2'd1 || pwr_state == 2'd0));
  p_sleep_exit_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'd2 |=> (pwr_state == 2'd2 || pwr_state == 2'd3));

  // R11: clock activity during conversion is flagged and the flag sticks
  p_sck_in_conv_r11: assert property (@(posedge clk) disable iff (rst)
    busy && (sck != $past(sck)) |=> proto_err);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    $past(proto_err) |-> proto_err);
endmodule

bind adc_port_model adc_port_checker #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .convst    (convst),
  .sck       (sck),
  .busy      (busy),
  .sdo_oe    (sdo_oe),
  .proto_err (proto_err),
  .pwr_state (pwr_state)
);

// File: tb/adc_port_model_test.sv
module adc_port_model_test;
  localparam int CLK_P = 10;
  localparam int DW    = 12;
  localparam int CONV  = 20;
  localparam int WAKE  = 40;

  logic clk = 1'b0, rst = 1'b1, convst = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [DW-1:0] sample = '0;
  logic sdo, sdo_oe, busy, acq_ready, proto_err;
  logic [3:0] mux_sel;
  logic [1:0] pwr_state;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$], got_q[$];

  always #(CLK_P/2) clk = ~clk;

  adc_port_model #(.DATA_W(DW), .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst(rst), .convst(convst), .sck(sck), .sdi(sdi),
    .sample_in(sample), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
    .acq_ready(acq_ready), .mux_sel(mux_sel), .pwr_state(pwr_state),
    .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs each expected word with the word read back.
  initial begin
    forever begin
      wait (got_q.size() != 0 && exp_q.size() != 0);
      begin
        logic [DW-1:0] g, e;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        check("R4 R5 serial word", 32'(g), 32'(e));
      end
    end
  end

  // Driver: reads DW bits and writes the six configuration bits, top bit first.
  task automatic frame(input logic [5:0] cfg, input logic [DW-1:0] exp);
    logic [DW-1:0] got;
    got = '0;
    exp_q.push_back(exp);
    for (int i = 0; i < DW; i++) begin
      @(negedge clk);
      got[DW-1-i] = sdo;
      sck = 1'b1;
      sdi = (i < 6) ? cfg[5-i] : 1'b0;
      @(negedge clk);
      sck = 1'b0;
    end
    @(negedge clk);
    got_q.push_back(got);
  endtask

  task automatic start_conv(input logic [DW-1:0] s);
    @(negedge clk);
    sample = s;
    convst = 1'b1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 pwr", 32'(pwr_state), 0);
    check("R1 err", 32'(proto_err), 0);
    check("R1 acq", 32'(acq_ready), 0);
    check("R1 mux", 32'(mux_sel), 0);

    // Conversion 1: reset config (two's complement); convst re-raised mid-conversion.
    start_conv(12'h0A5);
    for (int i = 1; i <= CONV + 1; i++) begin
      @(negedge clk);
      if (i == 2) convst = 1'b0;
      if (i == 3) check("R3 hiz while busy", 32'(sdo_oe), 0);
      if (i == 4) convst = 1'b1;
      if (i == 6) convst = 1'b0;
      if (i == CONV) check("R2 still busy", 32'(busy), 1);
      if (i == CONV + 1) begin
        check("R2 busy ends, no restart", 32'(busy), 0);
        check("R3 driven after end", 32'(sdo_oe), 1);
        check("R4 MSB at end", 32'(sdo), 1);
        check("R9 convst low stays active", 32'(pwr_state), 0);
      end
    end
    frame(6'b000010, 12'h0A5 ^ 12'h800);   // R5 bipolar: top bit inverted
    check("R7 acq after six bits", 32'(acq_ready), 1);

    // Conversion 2: straight binary, nap.
    start_conv(12'h3C7);
    @(negedge clk);
    check("R7 acq cleared on start", 32'(acq_ready), 0);
    check("R3 hiz while convst high", 32'(sdo_oe), 0);
    repeat (CONV + 1) @(negedge clk);
    check("R9 nap entry", 32'(pwr_state), 1);
    check("R3 hiz in nap", 32'(sdo_oe), 0);
    @(negedge clk); convst = 1'b0;
    @(negedge clk);
    check("R10 nap exit", 32'(pwr_state), 0);
    check("R3 driven after fall", 32'(sdo_oe), 1);
    frame(6'b100011, 12'h3C7);

    // Conversion 3: config from previous frame, sleep and wake window.
    start_conv(12'hFFF);
    @(negedge clk);
    check("R8 R6 mux code", 32'(mux_sel), 32'h8);
    repeat (CONV + 1) @(negedge clk);
    check("R9 sleep entry", 32'(pwr_state), 2);
    @(negedge clk); convst = 1'b0;
    for (int i = 1; i <= WAKE + 1; i++) begin
      @(negedge clk);
      if (i == 1)        check("R10 waking start", 32'(pwr_state), 3);
      if (i == WAKE)     check("R10 waking end", 32'(pwr_state), 3);
      if (i == WAKE + 1) check("R10 active after wake", 32'(pwr_state), 0);
    end
    frame(6'b000000, 12'hFFF);

    // Conversion 4: two's complement of midscale is zero.
    start_conv(12'h800);
    @(negedge clk); convst = 1'b0;
    repeat (CONV + 1) @(negedge clk);
    check("R9 active", 32'(pwr_state), 0);
    frame(6'b000001, 12'h000);
    check("R11 no error yet", 32'(proto_err), 0);

    // Error: sck during conversion.
    start_conv(12'h555);
    @(negedge clk); convst = 1'b0; sck = 1'b1;
    @(negedge clk); sck = 1'b0;
    @(negedge clk);
    check("R11 sck in conversion", 32'(proto_err), 1);
    wait_idle();
    check("R11 sticky", 32'(proto_err), 1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 err cleared by reset", 32'(proto_err), 0);
    check("R1 pwr after reset", 32'(pwr_state), 0);

    // Error: conversion start while waking.
    start_conv(12'h123);
    @(negedge clk); convst = 1'b0;
    wait_idle();
    frame(6'b000001, 12'h923);
    start_conv(12'h000);
    repeat (CONV + 2) @(negedge clk);
    check("R9 sleep via slp bit", 32'(pwr_state), 2);
    @(negedge clk); convst = 1'b0;
    @(negedge clk);
    check("R10 waking", 32'(pwr_state), 3);
    convst = 1'b1;
    @(negedge clk);
    check("R11 start while waking", 32'(proto_err), 1);
    convst = 1'b0;
    wait_idle();
    wait (got_q.size() == 0);
    finish_run();
  end
endmodule